// File: doc/BRIEF.md
# Write-Combining Buffer with Timeout Flush

This block sits between a producer of 32-bit words and a shared memory port. Words are held in a small queue rather than sent one at a time. They leave as one contiguous burst, so the memory sees a few long transfers instead of many single-word transfers. A burst starts for one of two reasons: the number of held words reaches a configurable high-water level, or a flush timer expires. The timer bounds how long a word can sit in the buffer.

Two timer policies can be chosen. In idle policy, a short timer restarts on every accepted word and expires after 16 quiet cycles. In age policy, a long timer starts with the first word that enters an empty buffer. Later words do not affect it, and it expires 128 cycles after that first word. A burst keeps running while new words arrive during the drain, so it can grow past the high-water level. It ends only when the buffer is empty. Burst words carry a word address that starts at zero after reset and rises by one for each word the memory accepts.

Top module: `write_combine_buffer`

## Requirements
- R1: After reset, `out_valid` and `burst_busy` are 0 and `in_ready` is 1.
- R2: When the held word count reaches `cfg_hiwater` (tested at 8, 4 and 16), `out_valid` rises on the next clock edge.
- R3: With 16 words held, `in_ready` is 0. Words offered while it is 0 are not stored and never appear at the output.
- R4: With `cfg_age_mode` = 0 (idle policy), each accepted word restarts the timer. `out_valid` rises 17 clock edges after the accepting edge of the last word if no flush was started earlier.
- R5: With `cfg_age_mode` = 1 (age policy), `out_valid` rises 129 clock edges after the edge that accepted the first word into the empty buffer. Words accepted later do not move this point.
- R6: Burst words leave in arrival order. `out_addr` starts at 0 after reset and rises by 1 for each word accepted at the output, across bursts.
- R7: `burst_busy` stays 1 from the start of a burst until the edge that accepts the last held word. Words accepted during the drain join the same burst.
- R8: `cfg_age_mode` and `cfg_hiwater` take effect only while the buffer is empty. A change while words are held does not alter the pending flush.
- R9: Once a flush empties the buffer, no further burst starts until a new word is accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | 32 | Producer word |
| in_ready | output | 1 | Buffer can accept a word (not full) |
| out_valid | output | 1 | Burst word available |
| out_ready | input | 1 | Memory accepts the current burst word |
| out_data | output | 32 | Burst word data |
| out_addr | output | 16 | Word address of the current burst word |
| burst_busy | output | 1 | A burst is in progress |
| cfg_age_mode | input | 1 | 0 selects idle-restart timer, 1 selects age timer |
| cfg_hiwater | input | 5 | Held-word count that starts a burst |

## Verification
Every output result is due at an exact clock edge, counted from the edge that accepts the triggering word:

- **Threshold trigger:** `out_valid` rises one edge after the count register reaches the high-water level.
- **Idle timer:** `out_valid` rises 17 edges after the last write.
- **Age timer:** `out_valid` rises 129 edges after the first write into the empty buffer.

The bench drives inputs and samples outputs 1 ns after each rising edge. For each trigger it checks that `out_valid` is still 0 one edge before the due edge and is 1 at the due edge, so both early and late bursts are caught. The drain checks compare each word when it is presented and before the edge that consumes it, so data, address order and burst continuity are checked word by word.

// File: rtl/wcb_pkg.sv
// Package: shared types and defaults for the write-combining buffer.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package wcb_pkg;

    // Flush timer policy selection
    typedef enum logic {
        TMO_IDLE = 1'b0,   // restart on every accepted word
        TMO_AGE  = 1'b1    // start on first word, ignore later ones
    } tmo_mode_e;

    localparam int DEF_DATA_W     = 32;
    localparam int DEF_ADDR_W     = 16;
    localparam int DEF_DEPTH      = 16;
    localparam int DEF_IDLE_LIMIT = 16;
    localparam int DEF_AGE_LIMIT  = 128;

    // Larger of two integers, used to size shared counters
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wcb_store.sv
// Module: wcb_store
// Circular word queue with a fill count. One push and one pop per cycle,
// both allowed together. Assumes the caller never pushes when full nor
// pops when empty; head data is read combinationally.
module wcb_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     fill,
    output logic              full
);

    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr;
    logic [PW-1:0]     rptr;
    logic [PW-1:0]     wptr_nxt;
    logic [PW-1:0]     rptr_nxt;

    // Pointer advance: plain wrap for power-of-two depth, compare otherwise
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wptr_nxt = wptr + 1'b1;
            assign rptr_nxt = rptr + 1'b1;
        end else begin : g_npow2
            assign wptr_nxt = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            assign rptr_nxt = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
        end
    endgenerate

    // Storage write: capture the pushed word at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= wptr_nxt;
            if (pop)  rptr <= rptr_nxt;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Head word and full flag for the surrounding logic
    assign head_data = mem[rptr];
    assign full      = (fill == CW'(DEPTH));

endmodule

// File: rtl/wcb_flush_timer.sv
// Module: wcb_flush_timer
// Staleness timer. Idle policy re-arms on every push; age policy arms only
// on the first push after disarm. The trip output stays high once reached
// until clear. Assumes clear is held during a drain so the timer restarts
// from a disarmed state once the buffer empties.
module wcb_flush_timer
    import wcb_pkg::*;
#(
    parameter int IDLE_LIMIT = 16,
    parameter int AGE_LIMIT  = 128,
    localparam int TW        = $clog2(imax(IDLE_LIMIT, AGE_LIMIT) + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tmo_mode_e mode,
    input  logic      push,
    input  logic      clear,
    output logic      trip
);

    localparam logic [TW-1:0] IDLE_L = TW'(IDLE_LIMIT);
    localparam logic [TW-1:0] AGE_L  = TW'(AGE_LIMIT);

    logic          armed;
    logic [TW-1:0] tmr;
    logic [TW-1:0] limit;
    logic          rearm;

    // Limit and re-arm decision for the selected policy
    always_comb begin
        limit = (mode == TMO_AGE) ? AGE_L : IDLE_L;
        rearm = push && ((mode == TMO_IDLE) || !armed);
    end

    // Counter: clear, re-arm, or count up to the limit and hold there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            tmr   <= '0;
        end else if (clear) begin
            armed <= 1'b0;
            tmr   <= '0;
        end else if (rearm) begin
            armed <= 1'b1;
            tmr   <= '0;
        end else if (armed && (tmr != limit)) begin
            tmr   <= tmr + 1'b1;
        end
    end

    // Expiry flag
    assign trip = armed && (tmr == limit);

endmodule

// File: rtl/wcb_drain_ctl.sv
// Module: wcb_drain_ctl
// Burst sequencer. Starts a drain when words are held and either the count
// reaches the high-water level or the timer has tripped. Keeps draining
// until the last held word is popped with no new word arriving. Owns the
// output word address, which increments per accepted word.
module wcb_drain_ctl #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     fill,
    input  logic [CW-1:0]     hiwater,
    input  logic              trip,
    input  logic              push,
    input  logic              pop,
    output logic              draining,
    output logic [ADDR_W-1:0] addr
);

    logic start_req;
    logic last_out;

    // Start and end conditions of a burst
    always_comb begin
        start_req = (fill != '0) && ((fill >= hiwater) || trip);
        last_out  = pop && (fill == CW'(1)) && !push;
    end

    // Burst state: idle until a start request, busy until emptied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining <= 1'b0;
        end else if (!draining) begin
            draining <= start_req;
        end else if (last_out) begin
            draining <= 1'b0;
        end
    end

    // Output word address: advances once per accepted burst word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (pop) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/write_combine_buffer.sv
// Module: write_combine_buffer (top)
// Collects producer words and releases them to memory as bursts started by
// a fill threshold or a staleness timer. Configuration is captured only
// while the buffer is empty and frozen while words are held. Assumes the
// producer holds in_valid/in_data until in_ready, and the memory side holds
// out_ready as its own decision (no combinational path back required).
module write_combine_buffer
    import wcb_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DEPTH      = DEF_DEPTH,
    parameter int IDLE_LIMIT = DEF_IDLE_LIMIT,
    parameter int AGE_LIMIT  = DEF_AGE_LIMIT,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              burst_busy,
    input  logic              cfg_age_mode,
    input  logic [CW-1:0]     cfg_hiwater
);

    logic          push;
    logic          pop;
    logic          full;
    logic [CW-1:0] fill;
    logic          trip;
    logic          draining;
    tmo_mode_e     mode_q;
    logic [CW-1:0] hiwater_q;

    // Handshake decode
    always_comb begin
        push = in_valid && !full;
        pop  = draining && out_ready;
    end

    // Configuration capture: follow inputs only while nothing is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= TMO_IDLE;
            hiwater_q <= CW'(DEPTH);
        end else if (fill == '0) begin
            mode_q    <= tmo_mode_e'(cfg_age_mode);
            hiwater_q <= cfg_hiwater;
        end
    end

    wcb_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (in_data),
        .pop       (pop),
        .head_data (out_data),
        .fill      (fill),
        .full      (full)
    );

    wcb_flush_timer #(
        .IDLE_LIMIT (IDLE_LIMIT),
        .AGE_LIMIT  (AGE_LIMIT)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .push  (push),
        .clear (draining),
        .trip  (trip)
    );

    wcb_drain_ctl #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) drain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill),
        .hiwater  (hiwater_q),
        .trip     (trip),
        .push     (push),
        .pop      (pop),
        .draining (draining),
        .addr     (out_addr)
    );

    // Output flags
    assign in_ready   = !full;
    assign out_valid  = draining;
    assign burst_busy = draining;

endmodule

// File: rtl/wcb_checker.sv
// Module: wcb_checker
// Protocol and occupancy properties for write_combine_buffer, bound to
// every instance of the top. Observes ports plus the internal fill count.
module wcb_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              burst_busy,
    input logic [CW-1:0]     fill
);

    // R3: held count never exceeds capacity
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R3: producer is stalled whenever the buffer is full
    assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH)) |-> !in_ready);

    // R10: stalled burst word holds still
    assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_addr)));

    // R6: address advances by one after each accepted word
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (out_addr == ADDR_W'($past(out_addr) + 1'b1)));

    // R7: a burst cannot end without a word being accepted
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy && !(out_valid && out_ready)) |=> burst_busy);

    // R9: nothing is offered from an empty buffer
    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !out_valid);

endmodule

bind write_combine_buffer wcb_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_addr   (out_addr),
    .burst_busy (burst_busy),
    .fill       (fill)
);

// File: tb/write_combine_buffer_tb_top.sv
// Directed bench for write_combine_buffer: one task per scenario.
module write_combine_buffer_tb_top;

    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [AW-1:0] out_addr;
    logic          burst_busy;
    logic          cfg_age_mode = 1'b0;
    logic [4:0]    cfg_hiwater = 5'd16;

    int            n_checks = 0;
    int            n_fail = 0;
    logic [DW-1:0] exp_q [$];
    logic [AW-1:0] exp_addr = '0;
    int            next_val = 32'h1000;

    always #2 clk = ~clk;   // 250 MHz

    write_combine_buffer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_addr     (out_addr),
        .burst_busy   (burst_busy),
        .cfg_age_mode (cfg_age_mode),
        .cfg_hiwater  (cfg_hiwater)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one word for a single cycle; caller ensures in_ready
    task automatic push_one();
        in_valid = 1'b1;
        in_data  = next_val;
        exp_q.push_back(next_val);
        next_val++;
        step();
        in_valid = 1'b0;
    endtask

    // Accept words until the model queue is empty, checking order and address
    task automatic drain_expect(input string req);
        out_ready = 1'b1;
        for (int guard = 0; guard < 400 && exp_q.size() != 0; guard++) begin
            if (out_valid) begin
                check({req, " R6 data"}, out_data, exp_q.pop_front());
                check({req, " R6 addr"}, 32'(out_addr), 32'(exp_addr));
                exp_addr++;
            end
            step();
        end
        check({req, " drained"}, 32'(exp_q.size()), 0);
        check({req, " R7 busy low after last"}, 32'(burst_busy), 0);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 burst_busy", 32'(burst_busy), 0);
        check("R1 in_ready", 32'(in_ready), 1);
    endtask

    task automatic t_idle_timer();
        cfg_age_mode = 1'b0; cfg_hiwater = 5'd16; step();
        push_one();
        repeat (16) step();
        check("R4 idle not before 17", 32'(out_valid), 0);
        step();
        check("R4 idle at 17", 32'(out_valid), 1);
        drain_expect("R4");
    endtask

    task automatic t_idle_restart();
        push_one();
        repeat (9) step();
        push_one();
        repeat (16) step();
        check("R4 restart not before 17", 32'(out_valid), 0);
        step();
        check("R4 restart at 17", 32'(out_valid), 1);
        drain_expect("R4 restart");
    endtask

    task automatic t_age_timer();
        cfg_age_mode = 1'b1; step();
        push_one();
        repeat (50) step();
        push_one();
        repeat (77) step();
        check("R5 age not before 129", 32'(out_valid), 0);
        step();
        check("R5 age at 129", 32'(out_valid), 1);
        drain_expect("R5");
        cfg_age_mode = 1'b0; step();
    endtask

    task automatic t_cfg_frozen();
        cfg_age_mode = 1'b0; step();
        push_one();
        cfg_age_mode = 1'b1;   // change while held: must not apply
        repeat (16) step();
        check("R8 frozen not before 17", 32'(out_valid), 0);
        step();
        check("R8 idle policy kept", 32'(out_valid), 1);
        drain_expect("R8");
        cfg_age_mode = 1'b0; step();
    endtask

    task automatic t_hiwater_hold();
        logic [DW-1:0] first;
        cfg_hiwater = 5'd8; step();
        first = next_val;
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1;
            in_data  = next_val;
            exp_q.push_back(next_val);
            next_val++;
            step();
        end
        in_valid = 1'b0;
        check("R2 not before count edge", 32'(out_valid), 0);
        step();
        check("R2 burst at 8", 32'(out_valid), 1);
        repeat (3) step();
        check("R10 valid held", 32'(out_valid), 1);
        check("R10 data held", out_data, first);
        check("R10 addr held", 32'(out_addr), 32'(exp_addr));
        drain_expect("R2");
    endtask

    task automatic t_full();
        cfg_hiwater = 5'd16; step();
        for (int i = 0; i < 16; i++) begin
            in_valid = 1'b1;
            in_data  = next_val;
            exp_q.push_back(next_val);
            next_val++;
            step();
        end
        check("R3 stalled at 16", 32'(in_ready), 0);
        in_data = 32'hDEAD_BEEF;   // offered while full: must be dropped
        step();
        step();
        in_valid = 1'b0;
        check("R3 still stalled", 32'(in_ready), 0);
        check("R2 burst at 16", 32'(out_valid), 1);
        drain_expect("R3");
        repeat (4) step();
        check("R3 rejected word absent", 32'(out_valid), 0);
    endtask

    task automatic t_grow();
        int bursts = 0;
        int pushed = 0;
        logic prev_busy = 1'b0;
        cfg_hiwater = 5'd4; step();
        out_ready = 1'b1;
        for (int guard = 0; guard < 200 && (pushed < 12 || exp_q.size() != 0); guard++) begin
            if (burst_busy && !prev_busy) bursts++;
            prev_busy = burst_busy;
            if (out_valid) begin
                check("R7 grow data", out_data, exp_q.pop_front());
                check("R7 grow addr", 32'(out_addr), 32'(exp_addr));
                exp_addr++;
            end
            if (pushed < 12) begin
                in_valid = 1'b1;
                in_data  = next_val;
                exp_q.push_back(next_val);
                next_val++;
                pushed++;
            end else begin
                in_valid = 1'b0;
            end
            step();
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check("R7 single burst for 12 words", 32'(bursts), 1);
        check("R7 busy low after drain", 32'(burst_busy), 0);
    endtask

    task automatic t_quiet();
        int seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (out_valid) seen++;
            step();
        end
        check("R9 no burst after empty", 32'(seen), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_timer();
        t_idle_restart();
        t_age_timer();
        t_cfg_frozen();
        t_hiwater_hold();
        t_full();
        t_grow();
        t_quiet();
        finish_run();
    end

endmodule